// File: doc/BRIEF.md
# Bunch Occupancy Histogram

This block watches one channel of aligned trigger data and builds a histogram of where, inside the machine orbit, energetic crossings occur. A position counter restarts at every orbit marker and advances by one per clock. Each clock, if the channel energy is strictly above a programmable threshold, the count for the current position is incremented. After many orbits the histogram shows the bunch fill pattern. If the channel delay is wrong, the whole pattern shifts by that many positions, which is how alignment is checked.

The counts are kept in an on-chip memory and updated by a pipelined read-modify-write. A clear command walks the whole address range and writes zero to every bin, with a busy flag raised for the duration of the walk. When accumulation is stopped, a host reads any bin through a plain synchronous read port.

Top module: `bunch_histogram`

## Requirements
- R1: The crossing presented together with `orbit_mark` has position 0. Each following cycle the position increases by one. After position ORBIT_LEN-1 it returns to 0 even when no marker arrives.
- R2: After reset, no bin changes until the first `orbit_mark` has been seen. From then on, counting stays enabled.
- R3: A crossing counts only when `energy` is strictly greater than `threshold`. An energy equal to the threshold does not count.
- R4: Only positions 0 to BINS-1 have bins. Crossings at higher positions are dropped and do not alias into low bins.
- R5: No bin changes while `run` is 0 or `busy` is 1.
- R6: Consecutive counts to the same bin on back-to-back cycles are all kept. N qualifying crossings give a count of N.
- R7: A bin that reaches 2^CNT_W-1 stays there on further hits.
- R8: A one-cycle `clear` pulse while `busy` is 0 raises `busy` on the next cycle. `busy` stays high for exactly BINS cycles, and afterwards every bin reads 0.
- R9: While `run` is 0 and `busy` is 0, `rd_data` shows the bin at the `rd_addr` value of the previous cycle.
- R10: After reset, `busy` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| energy | input | DATA_W | Aligned channel energy for this crossing |
| orbit_mark | input | 1 | Marks the crossing at orbit position 0 |
| threshold | input | DATA_W | Counting threshold (strict greater-than) |
| run | input | 1 | Accumulation enable |
| clear | input | 1 | Starts the zeroing sweep |
| rd_addr | input | $clog2(BINS) | Host read address |
| rd_data | output | CNT_W | Count of the addressed bin, one cycle later |
| busy | output | 1 | High while the zeroing sweep runs |

## Verification
The hardest state to reach is a long, unbroken chain of updates to a single bin. That chain exercises the forwarding path on every cycle and then carries the count into saturation. The bench holds `orbit_mark` high on every cycle with the threshold at zero, so every crossing lands on position 0. It reads the bin once after a short burst and again after the count must have clipped. Constrained-random orbits cover the rest: random energies, early markers, and one orbit left to wrap without a marker. A bench-side model of positions and counts supplies the expected value for every bin.

// File: rtl/hist_pkg.sv
package hist_pkg;
  // Strict comparison: equal energy does not qualify.
  function automatic logic above_threshold(input logic [31:0] e, input logic [31:0] t);
    return e > t;
  endfunction

  // Increment that clips at top_val.
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] top_val);
    return (v >= top_val) ? top_val : v + 32'd1;
  endfunction
endpackage

// File: rtl/hist_bx_counter.sv
module hist_bx_counter #(
  parameter int ORBIT_LEN = 3564,
  localparam int BXW = $clog2(ORBIT_LEN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mark,
  output logic [BXW-1:0] pos,
  output logic           locked
);
  localparam logic [BXW-1:0] LAST = BXW'(ORBIT_LEN - 1);

  logic [BXW-1:0] bx_q;
  logic           locked_q;

  always_comb begin
    if (mark)              pos = '0;
    else if (bx_q == LAST) pos = '0;
    else                   pos = bx_q + 1'b1;
  end

  assign locked = locked_q | mark;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bx_q     <= LAST;
      locked_q <= 1'b0;
    end else begin
      bx_q     <= pos;
      locked_q <= locked_q | mark;
    end
  end

  AST_BX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!mark && bx_q != LAST) |=> (bx_q == $past(bx_q) + 1'b1)); // R1
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q); // R2
endmodule

// File: rtl/hist_mem.sv
module hist_mem #(
  parameter int DEPTH = 1024,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  q
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Read-before-write: a read and a write to the same address on one edge return the old value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= mem[raddr];
  end
endmodule

// File: rtl/hist_clear_seq.sv
module hist_clear_seq #(
  parameter int BINS = 1024,
  localparam int AW  = $clog2(BINS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  output logic          busy,
  output logic [AW-1:0] clr_addr
);
  localparam logic [AW-1:0] TOP = AW'(BINS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      clr_addr <= '0;
    end else if (busy) begin
      if (clr_addr == TOP) busy <= 1'b0;
      else                 clr_addr <= clr_addr + 1'b1;
    end else if (clear) begin
      busy     <= 1'b1;
      clr_addr <= '0;
    end
  end

  AST_CLR_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> (clr_addr == '0)); // R8
endmodule

// File: rtl/bunch_histogram.sv
module bunch_histogram #(
  parameter int DATA_W    = 8,
  parameter int BINS      = 1024,
  parameter int CNT_W     = 16,
  parameter int ORBIT_LEN = 3564,
  localparam int AW  = $clog2(BINS),
  localparam int BXW = $clog2(ORBIT_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] energy,
  input  logic              orbit_mark,
  input  logic [DATA_W-1:0] threshold,
  input  logic              run,
  input  logic              clear,
  input  logic [AW-1:0]     rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              busy
);
  import hist_pkg::*;

  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

  logic [BXW-1:0]   pos;
  logic             locked;
  logic [AW-1:0]    clr_addr;
  logic             in_window;
  logic             upd_fire;
  logic             s1_valid;
  logic [AW-1:0]    s1_addr;
  logic             fwd_valid;
  logic [AW-1:0]    fwd_addr;
  logic [CNT_W-1:0] fwd_data;
  logic [CNT_W-1:0] mem_q;
  logic [CNT_W-1:0] src;
  logic [CNT_W-1:0] bumped;
  logic             mem_we;
  logic [AW-1:0]    mem_waddr;
  logic [CNT_W-1:0] mem_wdata;
  logic [AW-1:0]    mem_raddr;

  hist_bx_counter #(.ORBIT_LEN(ORBIT_LEN)) u_bx (
    .clk(clk), .rst_n(rst_n), .mark(orbit_mark), .pos(pos), .locked(locked)
  );

  hist_clear_seq #(.BINS(BINS)) u_clr (
    .clk(clk), .rst_n(rst_n), .clear(clear), .busy(busy), .clr_addr(clr_addr)
  );

  // Stage 0: qualify the crossing and issue the read.
  assign in_window = 32'(pos) < BINS;
  assign upd_fire  = run && !busy && locked && in_window &&
                     above_threshold(32'(energy), 32'(threshold));
  assign mem_raddr = upd_fire ? AW'(pos) : rd_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_addr   <= '0;
      fwd_valid <= 1'b0;
      fwd_addr  <= '0;
      fwd_data  <= '0;
    end else begin
      s1_valid  <= upd_fire;
      s1_addr   <= AW'(pos);
      fwd_valid <= s1_valid && !busy;
      fwd_addr  <= s1_addr;
      fwd_data  <= bumped;
    end
  end

  // Stage 1: take the fresh value from the last write if the read missed it, then increment.
  assign src    = (fwd_valid && fwd_addr == s1_addr) ? fwd_data : mem_q;
  assign bumped = CNT_W'(sat_inc(32'(src), 32'(MAXC)));

  // The sweep owns the write port while it runs.
  assign mem_we    = busy || s1_valid;
  assign mem_waddr = busy ? clr_addr : s1_addr;
  assign mem_wdata = busy ? '0 : bumped;

  hist_mem #(.DEPTH(BINS), .W(CNT_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .q(mem_q)
  );

  assign rd_data = mem_q;

  AST_NO_UPD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !s1_valid); // R5
  AST_THRESH_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> ($past(energy) > $past(threshold))); // R3
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && src == MAXC) |-> (bumped == MAXC)); // R7
  AST_FWD_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && $past(s1_valid) && !$past(busy) && s1_addr == $past(s1_addr))
      |-> (src == $past(bumped))); // R6
  AST_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> ($past(32'(pos)) < BINS)); // R4
endmodule

// File: tb/test_bunch_histogram.sv
module test_bunch_histogram;
  localparam int DATA_W = 8;
  localparam int BINS   = 64;
  localparam int CNT_W  = 12;
  localparam int OLEN   = 100;
  localparam int AW     = $clog2(BINS);
  localparam int MAXC   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DATA_W-1:0] energy = '0;
  logic orbit_mark = 1'b0;
  logic [DATA_W-1:0] threshold = '0;
  logic run = 1'b0;
  logic clear = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [CNT_W-1:0] rd_data;
  logic busy;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bunch_histogram #(.DATA_W(DATA_W), .BINS(BINS), .CNT_W(CNT_W), .ORBIT_LEN(OLEN)) i_bunch_histogram (
    .clk(clk), .rst_n(rst_n), .energy(energy), .orbit_mark(orbit_mark),
    .threshold(threshold), .run(run), .clear(clear), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );

  // Reference model, built from the requirements.
  int  m_bins [BINS];
  int  m_pos;
  bit  m_locked;

  function automatic int next_pos(input int cur, input bit mk);
    if (mk) return 0;
    return (cur == OLEN - 1) ? 0 : cur + 1;
  endfunction

  function automatic int clip_inc(input int v);
    return (v >= MAXC) ? MAXC : v + 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos    = OLEN - 1;
      m_locked = 1'b0;
    end else begin
      m_pos    = next_pos(m_pos, orbit_mark);
      m_locked = m_locked | orbit_mark;
      if (run && !busy && m_locked && m_pos < BINS && int'(energy) > int'(threshold))
        m_bins[m_pos] = clip_inc(m_bins[m_pos]);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int e, input bit mk);
    @(negedge clk);
    energy     = DATA_W'(e);
    orbit_mark = mk;
  endtask

  task automatic halt();
    @(negedge clk);
    run        = 1'b0;
    orbit_mark = 1'b0;
    energy     = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic read_check(input int a, input int exp, input string tag);
    rd_addr = AW'(a);
    @(negedge clk);
    check(tag, int'(rd_data), exp);
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < BINS; a++) read_check(a, m_bins[a], tag);
  endtask

  task automatic do_clear();
    int n;
    n = 0;
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    while (busy && n < 10 * BINS) begin
      n++;
      @(negedge clk);
    end
    check("R8 busy length", n, BINS);
    for (int a = 0; a < BINS; a++) m_bins[a] = 0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        report();
      end
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R10: reset values
    check("R10 busy", int'(busy), 0);
    check("R10 rd_data", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 / R9: sweep then read back zeros
    do_clear();
    read_all("R8 R9 zero after clear");

    // R2: energetic crossings before any marker
    run = 1'b1;
    threshold = '0;
    for (int i = 0; i < 30; i++) step(255, 1'b0);
    halt();
    read_all("R2 no count before marker");

    // R1 R3 R4: random orbits, early markers, one orbit wrapping without a marker
    threshold = 8'd100;
    run = 1'b1;
    for (int o = 0; o < 30; o++) begin
      int len;
      len = (o % 7 == 3) ? 40 + int'($urandom_range(0, 30)) : OLEN;
      for (int c = 0; c < len; c++) begin
        int e;
        e = (c % 5 == 0) ? 100 : int'($urandom_range(0, 255));
        step(e, (c == 0) && (o != 12));
      end
    end
    halt();
    read_all("R1 R3 R4 random orbits");

    // R3: directed equal/above threshold
    do_clear();
    run = 1'b1;
    threshold = 8'd50;
    step(50, 1'b1);
    step(51, 1'b0);
    halt();
    read_check(0, 0, "R3 equal not counted");
    read_check(1, 1, "R3 above counted");

    // R4: high positions do not alias
    run = 1'b1;
    step(0, 1'b1);
    for (int c = 1; c < OLEN; c++) step((c >= BINS) ? 255 : 0, 1'b0);
    halt();
    read_all("R4 outside window");

    // R5: hits while stopped
    for (int i = 0; i < 10; i++) step(255, i == 0);
    halt();
    read_all("R5 stopped");

    // R6: back-to-back hits on bin 0
    threshold = '0;
    run = 1'b1;
    for (int i = 0; i < 100; i++) step(255, 1'b1);
    halt();
    read_check(0, 100, "R6 back-to-back");
    read_check(0, m_bins[0], "R6 model");

    // R7: saturation
    run = 1'b1;
    for (int i = 0; i < MAXC + 50; i++) step(200, 1'b1);
    halt();
    read_check(0, MAXC, "R7 saturate");
    read_all("R7 others");

    done = 1'b1;
    report();
  end
endmodule